// File: doc/BRIEF.md
# Searchable Pipeline Queue

This block is a small synchronous queue placed between two pipeline stages. The producer stage pushes entries and the consumer stage pops them. Each entry carries three fields: a payload, a destination key, and a flag that says whether the entry will write a register. The consumer always sees the oldest entry on the head outputs. A flush input empties the queue in one cycle.

Besides pushing and popping, the producer can ask a combinational question: "does any entry still in the queue target this key?" The answer is true when at least one stored entry has its register-write flag set and a destination key equal to the queried key. Slots that hold no entry never match. A typical use is hazard detection, where a decode stage stalls while an older, uncompleted operation still intends to write a register that it wants to read.

Same-cycle ordering is chosen so the queue pipelines cleanly. Head read and pop happen first, then search and push, and flush comes last. As a result, a full queue accepts a push in the cycle it pops, and the search ignores the entry leaving that cycle. The search also does not yet see an entry being pushed in that cycle. A flush wins over any push or pop requested with it.

Top module: `srch_pipe_fifo`

## Requirements
- R1: While and after reset the queue is empty: `deq_ready` is 0, `enq_ready` is 1 and `find_hit` is 0.
- R2: Entries leave in the order they were accepted, each pop advancing the head by one entry.
- R3: When the queue holds DEPTH entries and `deq_req` is 0, `enq_ready` is 0 and a push request is dropped without altering the stored entries.
- R4: When the queue is full and a pop and a push are requested in the same cycle, both take effect: the occupancy stays DEPTH and the new entry becomes the youngest.
- R5: A pop request while the queue is empty has no effect and `deq_ready` is 0.
- R6: `find_hit` is 1 exactly when some stored entry has its write flag at 1 and its destination key equal to `find_key`.
- R7: An entry whose write flag is 0 never produces a hit, and neither does a slot freed by a pop or a flush.
- R8: In a cycle where a pop takes effect, the head entry being removed is excluded from the `find_hit` result.
- R9: An entry pushed in the current cycle is not visible to `find_hit` until the following cycle.
- R10: `clr` empties the queue at the next edge and overrides a push or pop requested in the same cycle.
- R11: Whenever `deq_ready` is 1, the head outputs `first_wr`, `first_dst` and `first_pay` carry the fields of the oldest stored entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Push request |
| enq_wr | input | 1 | Write flag of the pushed entry |
| enq_dst | input | KEY_W | Destination key of the pushed entry |
| enq_pay | input | PAY_W | Payload of the pushed entry |
| enq_ready | output | 1 | Push will be accepted this cycle |
| deq_req | input | 1 | Pop request |
| deq_ready | output | 1 | Queue is not empty; a pop will take effect |
| first_wr | output | 1 | Write flag of the oldest entry |
| first_dst | output | KEY_W | Destination key of the oldest entry |
| first_pay | output | PAY_W | Payload of the oldest entry |
| clr | input | 1 | Flush all entries |
| find_key | input | KEY_W | Key to search for |
| find_hit | output | 1 | A live, writing entry targets find_key |

## Verification
The bench focuses on the search and the pop landing in the same cycle, because the pop's effect on the search decides whether a consumer that is draining the queue unblocks the producer at once. This overlap is provoked on a full queue. The head entry is made the only writer of the searched key. The bench then requests a pop and a push together, and the search must miss while the push is still accepted. A plain queue model in the bench predicts every output on every cycle. It does this by counting only the entries that remain after the pop, and it also covers flush arriving together with a push.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    // Kind of occupancy change applied at the next edge
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_PUSH  = 3'd1,
        OP_POP   = 3'd2,
        OP_SWAP  = 3'd3,
        OP_FLUSH = 3'd4
    } sfifo_op_e;

endpackage

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl #(
    parameter int DEPTH = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enq_valid,
    input  logic          deq_req,
    input  logic          clr,
    output logic          enq_ready,
    output logic          deq_ready,
    output logic          enq_fire,
    output logic          deq_fire,
    output logic          flush,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [CW-1:0] cnt
);
    import sfifo_pkg::*;

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t     st_d, st_q;
    sfifo_op_e op;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        deq_ready = (st_q.cnt != '0);
        deq_fire  = deq_req && deq_ready;
        enq_ready = (st_q.cnt != CW'(DEPTH)) || deq_fire;
        enq_fire  = enq_valid && enq_ready && !clr;
        flush     = clr;

        if (clr)                        op = OP_FLUSH;
        else if (enq_fire && deq_fire)  op = OP_SWAP;
        else if (enq_fire)              op = OP_PUSH;
        else if (deq_fire)              op = OP_POP;
        else                            op = OP_HOLD;

        st_d = st_q;
        unique case (op)
            OP_FLUSH: st_d = '0;
            OP_PUSH: begin
                st_d.wr  = bump(st_q.wr);
                st_d.cnt = st_q.cnt + 1'b1;
            end
            OP_POP: begin
                st_d.rd  = bump(st_q.rd);
                st_d.cnt = st_q.cnt - 1'b1;
            end
            OP_SWAP: begin
                st_d.wr = bump(st_q.wr);
                st_d.rd = bump(st_q.rd);
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_ptr = st_q.wr;
    assign rd_ptr = st_q.rd;
    assign cnt    = st_q.cnt;

endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int DEPTH = 4,
    parameter int ENT_W = 14,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [PW-1:0]          wr_ptr,
    input  logic [ENT_W-1:0]       wr_data,
    input  logic                   rd_en,
    input  logic [PW-1:0]          rd_ptr,
    input  logic                   flush,
    output logic [ENT_W-1:0]       rd_data,
    output logic [DEPTH*ENT_W-1:0] ent_flat,
    output logic [DEPTH-1:0]       valid
);
    logic [ENT_W-1:0] mem_d [DEPTH];
    logic [ENT_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0] valid_d, valid_q;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        valid_d = valid_q;
        if (rd_en) valid_d[rd_ptr] = 1'b0;
        if (wr_en) begin
            mem_d[wr_ptr]   = wr_data;
            valid_d[wr_ptr] = 1'b1;
        end
        if (flush) valid_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            valid_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
            valid_q <= valid_d;
        end
    end

    assign rd_data = mem_q[rd_ptr];
    assign valid   = valid_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign ent_flat[g*ENT_W +: ENT_W] = mem_q[g];
    end

endmodule

// File: rtl/sfifo_match.sv
module sfifo_match #(
    parameter int DEPTH = 4,
    parameter int KEY_W = 5,
    parameter int PAY_W = 8,
    localparam int ENT_W = 1 + KEY_W + PAY_W,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic [DEPTH*ENT_W-1:0] ent_flat,
    input  logic [DEPTH-1:0]       valid,
    input  logic                   excl_en,
    input  logic [PW-1:0]          excl_ptr,
    input  logic [KEY_W-1:0]       key,
    output logic                   hit
);
    logic [DEPTH-1:0] slot_hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic [ENT_W-1:0] ent;
        logic             leaving;
        assign ent     = ent_flat[g*ENT_W +: ENT_W];
        assign leaving = excl_en && (excl_ptr == PW'(g));
        assign slot_hit[g] = valid[g] && !leaving && ent[ENT_W-1]
                             && (ent[PAY_W +: KEY_W] == key);
    end

    assign hit = |slot_hit;

endmodule

// File: rtl/srch_pipe_fifo.sv
module srch_pipe_fifo #(
    parameter int DEPTH = 4,
    parameter int KEY_W = 5,
    parameter int PAY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    input  logic             enq_wr,
    input  logic [KEY_W-1:0] enq_dst,
    input  logic [PAY_W-1:0] enq_pay,
    output logic             enq_ready,
    input  logic             deq_req,
    output logic             deq_ready,
    output logic             first_wr,
    output logic [KEY_W-1:0] first_dst,
    output logic [PAY_W-1:0] first_pay,
    input  logic             clr,
    input  logic [KEY_W-1:0] find_key,
    output logic             find_hit
);
    localparam int ENT_W = 1 + KEY_W + PAY_W;
    localparam int PW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);

    logic                   enq_fire, deq_fire, flush;
    logic [PW-1:0]          wr_ptr, rd_ptr;
    logic [CW-1:0]          cnt_w;
    logic [ENT_W-1:0]       head;
    logic [DEPTH*ENT_W-1:0] ent_flat;
    logic [DEPTH-1:0]       valid_w;

    sfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .deq_req(deq_req),
        .clr(clr), .enq_ready(enq_ready), .deq_ready(deq_ready),
        .enq_fire(enq_fire), .deq_fire(deq_fire), .flush(flush),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .cnt(cnt_w)
    );

    sfifo_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(enq_fire), .wr_ptr(wr_ptr),
        .wr_data({enq_wr, enq_dst, enq_pay}), .rd_en(deq_fire),
        .rd_ptr(rd_ptr), .flush(flush), .rd_data(head),
        .ent_flat(ent_flat), .valid(valid_w)
    );

    sfifo_match #(.DEPTH(DEPTH), .KEY_W(KEY_W), .PAY_W(PAY_W)) u_match (
        .ent_flat(ent_flat), .valid(valid_w), .excl_en(deq_fire),
        .excl_ptr(rd_ptr), .key(find_key), .hit(find_hit)
    );

    assign first_wr  = head[ENT_W-1];
    assign first_dst = head[PAY_W +: KEY_W];
    assign first_pay = head[0 +: PAY_W];

endmodule

// File: rtl/srch_pipe_fifo_chk.sv
module srch_pipe_fifo_chk #(
    parameter int DEPTH = 4,
    parameter int CW = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enq_valid,
    input logic             deq_req,
    input logic             clr,
    input logic             enq_ready,
    input logic             deq_ready,
    input logic             find_hit,
    input logic [CW-1:0]    cnt,
    input logic [DEPTH-1:0] valid
);
    // R2: occupancy counter agrees with the per-slot live bits
    always @(posedge clk) begin
        if (rst_n) begin
            p_cnt_live_r2: assert (32'(cnt) == 32'($countones(valid)));
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(DEPTH) && !deq_req) |-> !enq_ready);

    p_full_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(DEPTH) && deq_req && enq_valid && !clr) |=> (cnt == CW'(DEPTH)));

    p_empty_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !deq_ready |-> (valid == '0));

    p_empty_nohit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid == '0) |-> !find_hit);

    p_flush_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && !deq_ready));

endmodule

bind srch_pipe_fifo srch_pipe_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .deq_req(deq_req),
    .clr(clr), .enq_ready(enq_ready), .deq_ready(deq_ready),
    .find_hit(find_hit), .cnt(cnt_w), .valid(valid_w)
);

// File: tb/srch_pipe_fifo_bench.sv
`timescale 1ns/1ps
module srch_pipe_fifo_bench;
    localparam int DEPTH = 4;
    localparam int KEY_W = 5;
    localparam int PAY_W = 8;
    localparam int EW    = 1 + KEY_W + PAY_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enq_valid = 1'b0, enq_wr = 1'b0, deq_req = 1'b0, clr = 1'b0;
    logic [KEY_W-1:0] enq_dst = '0, find_key = '0;
    logic [PAY_W-1:0] enq_pay = '0;
    logic             enq_ready, deq_ready, first_wr, find_hit;
    logic [KEY_W-1:0] first_dst;
    logic [PAY_W-1:0] first_pay;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [EW-1:0] model [$];

    always #4 clk = ~clk;

    srch_pipe_fifo #(.DEPTH(DEPTH), .KEY_W(KEY_W), .PAY_W(PAY_W)) u_srch_pipe_fifo (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_wr(enq_wr),
        .enq_dst(enq_dst), .enq_pay(enq_pay), .enq_ready(enq_ready),
        .deq_req(deq_req), .deq_ready(deq_ready), .first_wr(first_wr),
        .first_dst(first_dst), .first_pay(first_pay), .clr(clr),
        .find_key(find_key), .find_hit(find_hit)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare combinational outputs, advance model at edge
    task automatic step(input string tag, input logic ev, input logic ew, input logic [KEY_W-1:0] ed,
                        input logic [PAY_W-1:0] ep, input logic dq, input logic cl, input logic [KEY_W-1:0] key);
        logic e_rdy, d_rdy, hit, d_fire, e_fire;
        enq_valid = ev; enq_wr = ew; enq_dst = ed; enq_pay = ep;
        deq_req = dq; clr = cl; find_key = key;
        #1;
        d_rdy  = (model.size() > 0);
        d_fire = dq && d_rdy;
        e_rdy  = (model.size() < DEPTH) || d_fire;
        e_fire = ev && e_rdy && !cl;
        hit = 1'b0;
        for (int i = (d_fire ? 1 : 0); i < model.size(); i++)
            if (model[i][EW-1] && model[i][PAY_W +: KEY_W] == key) hit = 1'b1;
        check(tag, "enq_ready", 32'(enq_ready), 32'(e_rdy));
        check(tag, "deq_ready", 32'(deq_ready), 32'(d_rdy));
        check(tag, "find_hit", 32'(find_hit), 32'(hit));
        if (d_rdy) check(tag, "first", 32'({first_wr, first_dst, first_pay}), 32'(model[0]));
        @(posedge clk);
        if (cl) model.delete();
        else begin
            if (d_fire) void'(model.pop_front());
            if (e_fire) model.push_back({ew, ed, ep});
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state observed while reset is held
        #1;
        check("R1", "enq_ready", 32'(enq_ready), 32'd1);
        check("R1", "deq_ready", 32'(deq_ready), 32'd0);
        check("R1", "find_hit", 32'(find_hit), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: key being pushed into an empty queue is not yet visible
        step("R9", 1, 1, 5'd3, 8'h11, 0, 0, 5'd3);
        step("R6", 1, 1, 5'd7, 8'h22, 0, 0, 5'd3);
        step("R7", 1, 0, 5'd9, 8'h33, 0, 0, 5'd9);
        step("R6", 1, 1, 5'd12, 8'h44, 0, 0, 5'd7);
        // R3: full, push without pop dropped
        step("R3", 1, 1, 5'd20, 8'h55, 0, 0, 5'd20);
        step("R7", 0, 0, 5'd0, 8'h00, 0, 0, 5'd9);
        step("R11", 0, 0, 5'd0, 8'h00, 0, 0, 5'd12);
        // R8 and R4: pop head (only writer of key 3) with push on full queue
        step("R8", 1, 1, 5'd3, 8'h66, 1, 0, 5'd3);
        step("R4", 0, 0, 5'd0, 8'h00, 0, 0, 5'd3);
        // R2: drain in order, R5: pop on empty
        for (int i = 0; i < 5; i++) step("R2", 0, 0, 5'd0, 8'h00, 1, 0, 5'd7);
        step("R5", 0, 0, 5'd0, 8'h00, 1, 0, 5'd3);
        step("R7", 0, 0, 5'd0, 8'h00, 0, 0, 5'd12);
        // R10: flush with concurrent push and pop
        step("R10", 1, 1, 5'd4, 8'h77, 0, 0, 5'd4);
        step("R10", 1, 1, 5'd5, 8'h88, 1, 1, 5'd4);
        step("R10", 0, 0, 5'd0, 8'h00, 0, 0, 5'd5);
        // R6: mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            step("R6", r[0] | r[1], r[2], KEY_W'(r[5:3]), PAY_W'(r[15:8]),
                 r[16] & r[17], (r[27:24] == 4'd0), KEY_W'(r[20:18]));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule